// File: doc/BRIEF.md
# Min-Sum LDPC Check Node Unit

This block performs the check node update of an LDPC decoder that uses a corrected (scaled and offset) min-sum rule. Every edge of one check node delivers a signed variable-to-check message in the same cycle. The unit finds the smallest incoming magnitude and the edge that carries it, and it makes a cheap estimate of the next-smallest magnitude. It forms the parity of all signs. The same shift-and-add correction is applied to both magnitudes, and the unit returns one check-to-variable message per edge one clock later. It suits a layered or a flooding schedule. Message storage, variable node work and permutation routing sit outside the block.

The scale factor is 0.75, written as m minus m shifted right by two, so no multiplier is needed. The offset is one LSB. The scaled value, the negated shift term and the offset are merged in one carry-save stage and then one carry-propagate add, and the result is clamped at zero. The second minimum is approximate. The inputs are split into a lower half and an upper half, and the minimum of the half that does not hold the overall minimum is used as the second minimum. A small two-state controller (ST_IDLE, ST_EMIT) produces the output valid. Transition T_ACCEPT goes from ST_IDLE to ST_EMIT on a valid input. T_STREAM stays in ST_EMIT on a valid input. T_DRAIN goes from ST_EMIT to ST_IDLE when no valid input arrives. ST_IDLE also stays in place when no valid input arrives.

Top module: `ldpc_cnu_top`

## Requirements
- R1: Edge i occupies bits [6i+5:6i] of both in_msg and out_msg, in sign-magnitude form. Bit 5 of the slice is the sign (1 = negative) and bits 4:0 are the magnitude. There are DEG = 8 edges by default, and DEG must be even.
- R2: out_valid is 1 in exactly the cycles that follow a cycle in which in_valid was 1 at the clock edge. Otherwise it is 0.
- R3: When in_valid is 0 at a clock edge, out_msg keeps its previous value.
- R4: While rst_n is low, out_valid and out_msg are both 0.
- R5: The first minimum is the smallest input magnitude. Its index is the lowest-numbered edge that carries that value.
- R6: The lower half is edges 0 to DEG/2-1 and the upper half is the rest. The second minimum is the minimum magnitude of the half that does not contain the first minimum's index. When the two halves tie, the lower half holds the index.
- R7: The correction maps a magnitude m to max(0, m - floor(m/4) - 1). For example, 0 maps to 0, 2 to 1, 10 to 7 and 31 to 23.
- R8: The output magnitude is the corrected second minimum on the first minimum's edge, and the corrected first minimum on every other edge.
- R9: The output sign of edge i is the XOR of all input signs, XORed with the sign of input i.
- R10: Valid inputs on back-to-back cycles each produce their own output, in order, with none lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | The input vector is valid this cycle |
| in_msg | input | DEG*6 | Variable-to-check messages, one 6-bit slice per edge |
| out_valid | output | 1 | The output vector is valid this cycle |
| out_msg | output | DEG*6 | Check-to-variable messages, one 6-bit slice per edge |

## Verification
Every result is due exactly one clock after the edge that captured its input. The bench therefore derives the expected out_valid from the in_valid it sampled at the previous rising edge, and it compares outputs at the falling edge that comes half a period later. Each driven vector puts a reference result, computed from the requirements, into a queue. The monitor pops one entry whenever out_valid is seen, so a missing, extra or reordered result is caught at the cycle where it should appear. Hand-computed literals for the approximate second minimum, the clamp and the sign parity are read at that same falling edge.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
    // Output controller states.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } cnu_state_t;

    // Width of one sign-magnitude message, given the magnitude width.
    function automatic int msg_width(input int magw);
        return magw + 1;
    endfunction
endpackage

// File: rtl/cnu_half_min.sv
// Minimum magnitude of one group of edges and the lowest index that carries it.
module cnu_half_min #(
    parameter int N     = 4,
    parameter int MAGW  = 5,
    parameter int IDXW  = 3,
    parameter int BASE  = 0
) (
    input  logic [N*MAGW-1:0] mags,
    output logic [MAGW-1:0]   min_mag,
    output logic [IDXW-1:0]   min_idx
);
    always_comb begin
        min_mag = mags[MAGW-1:0];
        min_idx = IDXW'(BASE);
        for (int j = 1; j < N; j++) begin
            // Strict compare keeps the lower index on a tie.
            if (mags[j*MAGW +: MAGW] < min_mag) begin
                min_mag = mags[j*MAGW +: MAGW];
                min_idx = IDXW'(BASE + j);
            end
        end
    end
endmodule

// File: rtl/cnu_correct.sv
// Computes max(0, m - (m>>2) - 1) with one carry-save stage and one final add.
module cnu_correct #(
    parameter int MAGW = 5
) (
    input  logic [MAGW-1:0] mag_in,
    output logic [MAGW-1:0] mag_out
);
    localparam int W = MAGW + 2;

    logic [W-1:0] term_a;
    logic [W-1:0] term_b;
    logic [W-1:0] term_c;
    logic [W-1:0] csa_sum;
    logic [W-1:0] csa_cry;
    logic [W-1:0] total;

    always_comb begin
        term_a  = {2'b00, mag_in};
        term_b  = ~({2'b00, mag_in} >> 2);   // with the +1 below, this is -(m>>2)
        term_c  = '1;                         // -1, the offset
        csa_sum = term_a ^ term_b ^ term_c;
        csa_cry = ((term_a & term_b) | (term_a & term_c) | (term_b & term_c)) << 1;
        total   = csa_sum + csa_cry + W'(1);
        mag_out = total[W-1] ? '0 : total[MAGW-1:0];
    end
endmodule

// File: rtl/ldpc_cnu_top.sv
module ldpc_cnu_top #(
    parameter int DEG  = 8,
    parameter int MAGW = 5
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             in_valid,
    input  logic [DEG*(MAGW+1)-1:0]          in_msg,
    output logic                             out_valid,
    output logic [DEG*(MAGW+1)-1:0]          out_msg
);
    import cnu_pkg::*;

    localparam int MSGW = msg_width(MAGW);
    localparam int HALF = DEG / 2;
    localparam int IDXW = (DEG > 1) ? $clog2(DEG) : 1;

    logic [DEG*MAGW-1:0] mag_vec;
    logic [DEG-1:0]      sgn_vec;
    logic                parity;

    for (genvar i = 0; i < DEG; i++) begin : g_unpack
        assign mag_vec[i*MAGW +: MAGW] = in_msg[i*MSGW +: MAGW];
        assign sgn_vec[i]              = in_msg[i*MSGW + MAGW];
    end

    assign parity = ^sgn_vec;

    // Two half searches; the second minimum comes from the losing half.
    logic [MAGW-1:0] h_min [2];
    logic [IDXW-1:0] h_idx [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        cnu_half_min #(
            .N    (HALF),
            .MAGW (MAGW),
            .IDXW (IDXW),
            .BASE (h * HALF)
        ) u_half (
            .mags    (mag_vec[h*HALF*MAGW +: HALF*MAGW]),
            .min_mag (h_min[h]),
            .min_idx (h_idx[h])
        );
    end

    logic            take_hi;
    logic [MAGW-1:0] first_min;
    logic [MAGW-1:0] second_min;
    logic [IDXW-1:0] first_idx;
    logic [MAGW-1:0] corr_first;
    logic [MAGW-1:0] corr_second;

    always_comb begin
        take_hi    = h_min[1] < h_min[0];
        first_min  = take_hi ? h_min[1] : h_min[0];
        first_idx  = take_hi ? h_idx[1] : h_idx[0];
        second_min = take_hi ? h_min[0] : h_min[1];
    end

    cnu_correct #(.MAGW(MAGW)) u_corr_first (
        .mag_in  (first_min),
        .mag_out (corr_first)
    );

    cnu_correct #(.MAGW(MAGW)) u_corr_second (
        .mag_in  (second_min),
        .mag_out (corr_second)
    );

    logic [DEG*MSGW-1:0] next_msg;

    always_comb begin
        for (int i = 0; i < DEG; i++) begin
            next_msg[i*MSGW + MAGW]  = parity ^ sgn_vec[i];
            next_msg[i*MSGW +: MAGW] = (IDXW'(i) == first_idx) ? corr_second : corr_first;
        end
    end

    // Output controller.
    cnu_state_t state_q;
    cnu_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_EMIT;   // T_ACCEPT
            ST_EMIT: if (!in_valid) state_d = ST_IDLE;   // T_DRAIN, else T_STREAM
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        out_msg <= '0;
        else if (in_valid) out_msg <= next_msg;
    end

    assign out_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/cnu_checker.sv
module cnu_checker #(
    parameter int DEG  = 8,
    parameter int MAGW = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [DEG*(MAGW+1)-1:0] in_msg,
    input logic                    out_valid,
    input logic [DEG*(MAGW+1)-1:0] out_msg
);
    localparam int MSGW  = MAGW + 1;
    localparam int MAXM  = (1 << MAGW) - 1;
    localparam int CMAX  = MAXM - MAXM / 4 - 1;

    logic in_par;
    logic out_par;
    logic over_lim;

    always_comb begin
        in_par   = 1'b0;
        out_par  = 1'b0;
        over_lim = 1'b0;
        for (int i = 0; i < DEG; i++) begin
            in_par  = in_par  ^ in_msg[i*MSGW + MAGW];
            out_par = out_par ^ out_msg[i*MSGW + MAGW];
            if (int'(out_msg[i*MSGW +: MAGW]) > CMAX) over_lim = 1'b1;
        end
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_msg));

    // R9: for an even degree, the XOR of all output signs equals the input parity.
    a_r9_sign_parity: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_par == $past(in_par)));

    // R7: a corrected magnitude never exceeds the correction of the largest input.
    a_r7_mag_limit: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !over_lim);
endmodule

bind ldpc_cnu_top cnu_checker #(.DEG(DEG), .MAGW(MAGW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_msg    (in_msg),
    .out_valid (out_valid),
    .out_msg   (out_msg)
);

// File: tb/sim_ldpc_cnu_top.sv
`timescale 1ns/1ps
module sim_ldpc_cnu_top;
    localparam int DEG  = 8;
    localparam int MAGW = 5;
    localparam int MSGW = MAGW + 1;
    localparam int VW   = DEG * MSGW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] in_msg = '0;
    logic          out_valid;
    logic [VW-1:0] out_msg;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ldpc_cnu_top #(.DEG(DEG), .MAGW(MAGW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_msg),
        .out_valid(out_valid), .out_msg(out_msg)
    );

    function automatic int corr(input int m);
        int r;
        r = m - m / 4 - 1;
        return (r < 0) ? 0 : r;
    endfunction

    // Reference result from R1, R5 to R9.
    function automatic logic [VW-1:0] ref_cnu(input logic [VW-1:0] v);
        logic [VW-1:0] o;
        int mags [DEG];
        int lo_min, hi_min, lo_idx, hi_idx, m1, m2, idx, par;
        par = 0;
        for (int i = 0; i < DEG; i++) begin
            mags[i] = int'(v[i*MSGW +: MAGW]);
            par ^= int'(v[i*MSGW + MAGW]);
        end
        lo_min = 99; hi_min = 99; lo_idx = 0; hi_idx = DEG/2;
        for (int i = DEG - 1; i >= 0; i--) begin
            if (i < DEG/2) begin
                if (mags[i] <= lo_min) begin lo_min = mags[i]; lo_idx = i; end
            end else begin
                if (mags[i] <= hi_min) begin hi_min = mags[i]; hi_idx = i; end
            end
        end
        if (hi_min < lo_min) begin m1 = hi_min; idx = hi_idx; m2 = lo_min; end
        else                 begin m1 = lo_min; idx = lo_idx; m2 = hi_min; end
        for (int i = 0; i < DEG; i++) begin
            o[i*MSGW + MAGW]  = 1'(par) ^ v[i*MSGW + MAGW];
            o[i*MSGW +: MAGW] = MAGW'((i == idx) ? corr(m2) : corr(m1));
        end
        return o;
    endfunction

    function automatic logic [VW-1:0] pack(input int m [DEG], input logic [DEG-1:0] s);
        logic [VW-1:0] v;
        for (int i = 0; i < DEG; i++) v[i*MSGW +: MSGW] = {s[i], MAGW'(m[i])};
        return v;
    endfunction

    logic [VW-1:0] exp_q [$];

    task automatic check(input string tag, input bit ok, input logic [VW-1:0] act, input logic [VW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, expv, $time);
        end
    endtask

    task automatic send(input logic [VW-1:0] v);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_msg   = v;
        exp_q.push_back(ref_cnu(v));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_msg   = {VW{1'b1}} ^ in_msg;   // noise on an idle input
        end
    endtask

    // Monitor: expected valid from the edge before, compare at the falling edge.
    logic          exp_v = 1'b0;
    logic [VW-1:0] last_out = '0;

    always @(posedge clk) exp_v <= rst_n ? in_valid : 1'b0;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 out_valid timing", out_valid == exp_v, VW'(out_valid), VW'(exp_v));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected result", 1'b0, out_msg, '0);
                end else begin
                    logic [VW-1:0] e;
                    e = exp_q.pop_front();
                    check("R1 R5 R6 R7 R8 R9 scoreboard", out_msg == e, out_msg, e);
                end
                last_out = out_msg;
            end else begin
                check("R3 hold while idle", out_msg == last_out, out_msg, last_out);
            end
        end
    end

    initial begin
        int m [DEG];
        logic [VW-1:0] lit;
        // R4: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R4 reset out_valid", out_valid == 1'b0, VW'(out_valid), '0);
        check("R4 reset out_msg", out_msg == '0, out_msg, '0);
        @(posedge clk); #1; rst_n = 1'b1;

        // R6: the two smallest are both in the lower half, so the estimate uses the upper half.
        m = '{2, 3, 9, 9, 10, 10, 10, 10};
        send(pack(m, 8'h00)); idle(1); @(negedge clk);
        // edge0 = c(10)=7, others = c(2)=1, signs 0
        lit = '0;
        for (int i = 0; i < DEG; i++) lit[i*MSGW +: MSGW] = (i == 0) ? 6'd7 : 6'd1;
        check("R6 approximate second minimum", out_msg == lit, out_msg, lit);

        // R5: tie on the minimum across halves resolves to the lowest index (edge 1).
        m = '{8, 4, 6, 7, 4, 4, 9, 5};
        send(pack(m, 8'b0000_0101)); idle(1); @(negedge clk);
        // min1=4 idx1, min2=upper half min 4 -> all mags c(4)=2; parity 0 -> sign = own sign
        lit = '0;
        for (int i = 0; i < DEG; i++) lit[i*MSGW +: MSGW] = {(i == 0 || i == 2), 5'd2};
        check("R5 R9 tie and signs", out_msg == lit, out_msg, lit);

        // R7: zero magnitudes clamp to zero; odd sign count flips every sign.
        m = '{0, 0, 0, 0, 0, 0, 0, 0};
        send(pack(m, 8'b0000_0001)); idle(1); @(negedge clk);
        lit = '0;
        for (int i = 1; i < DEG; i++) lit[i*MSGW + MAGW] = 1'b1;
        check("R7 clamp at zero", out_msg == lit, out_msg, lit);

        // R7 R8: full scale with the minimum in the upper half.
        m = '{31, 31, 31, 31, 31, 31, 2, 31};
        send(pack(m, 8'h00)); idle(1); @(negedge clk);
        lit = '0;
        for (int i = 0; i < DEG; i++) lit[i*MSGW +: MSGW] = (i == 6) ? 6'd23 : 6'd1;
        check("R7 R8 full scale, upper minimum", out_msg == lit, out_msg, lit);

        // R10: back-to-back burst, then random traffic with gaps.
        for (int n = 0; n < 20; n++) begin
            for (int i = 0; i < DEG; i++) m[i] = int'($urandom_range(0, 31));
            send(pack(m, DEG'($urandom)));
        end
        idle(2);
        for (int n = 0; n < 400; n++) begin
            for (int i = 0; i < DEG; i++) m[i] = int'($urandom_range(0, (n % 2) ? 31 : 5));
            send(pack(m, DEG'($urandom)));
            if ($urandom_range(0, 2) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(3);
        @(negedge clk);
        check("R10 all results delivered", exp_q.size() == 0, VW'(exp_q.size()), '0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule